// File: doc/BRIEF.md
# Hysteretic Input Level Detector

The block watches one port of signed 14-bit samples and raises a level flag when a sample's magnitude is loud enough. The flag can drive an external attenuator or gain switch. The flag rises at once when the magnitude reaches an upper threshold. It falls only after a run of quiet samples, each below a separate lower threshold, whose length is set by a dwell count. Any sample at or above the lower threshold during that run cancels the run, and the next quiet sample starts a full run again. The flag therefore does not chatter when the signal sits near a threshold.

Two detectors sit behind the same magnitude stage. In single mode every sample goes to detector A, and the second output carries the inverse of A's flag. In interleaved mode the enable bit of each sample picks its detector: low selects A and high selects B. Each detector then drives its own output.

Top module: `hyst_level_det`

## Requirements
- R1: While `rst` is high at a clock edge, both detectors become inactive with no quiet run in progress. Afterwards `flag_a_o` is 0, and `flag_b_o` is 1 in single mode (`ilv_i`=0) or 0 in interleaved mode (`ilv_i`=1).
- R2: The magnitude of a sample is its absolute value as an unsigned number. The code -8192 (0x2000) saturates to 8191. An inactive detector that receives a sample whose magnitude is >= `thr_hi_i` is active after that clock edge.
- R3: An active detector that receives a sample whose magnitude is >= `thr_lo_i` stays active.
- R4: An active detector goes inactive at the edge of the (N+1)-th consecutive sample routed to it with magnitude < `thr_lo_i`, where N is the value of `dwell_i` when the run began.
- R5: With `dwell_i` = 0, the first sample below `thr_lo_i` releases an active detector.
- R6: A sample at or above `thr_lo_i` during a quiet run cancels the run. The next quiet sample starts a full new run of N+1.
- R7: In interleaved mode, a sample with `en_i`=0 updates only detector A and a sample with `en_i`=1 updates only detector B. The detector that is not selected keeps its flag and its count. `flag_b_o` shows detector B.
- R8: In single mode every sample updates detector A whatever `en_i` is. Detector B is held cleared, and `flag_b_o` equals the inverse of `flag_a_o`.
- R9: Each flag changes at the clock edge that captures the deciding sample, so the latency is one cycle. An inactive detector never rises from a sample below `thr_hi_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_i | input | 14 | Two's-complement sample |
| en_i | input | 1 | Detector select in interleaved mode (0 = A, 1 = B) |
| ilv_i | input | 1 | 1 = interleaved mode, 0 = single mode |
| thr_hi_i | input | 14 | Upper threshold (unsigned magnitude) |
| thr_lo_i | input | 14 | Lower threshold (unsigned magnitude) |
| dwell_i | input | 16 | Extra quiet samples required before release |
| flag_a_o | output | 1 | Level flag of detector A |
| flag_b_o | output | 1 | Detector B flag (interleaved) or inverse of A (single) |

## Verification
The bound checker watches every cycle for four things. Detector A may rise only on a routed sample at or above the upper threshold and may fall only on a routed quiet sample. A loud-enough sample keeps an active flag up. Samples steered to the other detector leave a flag untouched, and the single-mode outputs are complementary. The length of a quiet run, its restart after a sample at or above the lower threshold, the zero-dwell case and the saturated magnitude of the most negative code all depend on sequences of samples. Only the bench's directed and randomized scenarios, compared against a reference model, can show those.

// File: rtl/hyst_level_det.sv
module hyst_level_det #(
  parameter int SW = 14,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] smp_i,
  input  logic          en_i,
  input  logic          ilv_i,
  input  logic [SW-1:0] thr_hi_i,
  input  logic [SW-1:0] thr_lo_i,
  input  logic [CW-1:0] dwell_i,
  output logic          flag_a_o,
  output logic          flag_b_o
);

  localparam logic [SW-1:0] MOST_NEG = {1'b1, {(SW-1){1'b0}}};
  localparam logic [SW-1:0] MAX_MAG  = {1'b0, {(SW-1){1'b1}}};

  logic [SW-1:0] mag;
  logic          loud, audible;
  logic [1:0]    sel, act;

  assign mag     = !smp_i[SW-1] ? smp_i : (smp_i == MOST_NEG) ? MAX_MAG : (~smp_i + 1'b1);
  assign loud    = mag >= thr_hi_i;
  assign audible = mag >= thr_lo_i;
  assign sel[0]  = !ilv_i || !en_i;
  assign sel[1]  = ilv_i && en_i;

  for (genvar g = 0; g < 2; g++) begin : g_det
    logic          act_q, run_q;
    logic [CW-1:0] cnt_q, rem;
    logic          clr;

    assign rem    = run_q ? cnt_q : dwell_i;
    assign clr    = rst || (g == 1 && !ilv_i);
    assign act[g] = act_q;

    always_ff @(posedge clk) begin
      if (clr) begin
        act_q <= 1'b0;
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (sel[g]) begin
        if (!act_q) begin
          if (loud) act_q <= 1'b1;
        end else if (audible) begin
          run_q <= 1'b0;
        end else if (rem == '0) begin
          act_q <= 1'b0;
          run_q <= 1'b0;
        end else begin
          run_q <= 1'b1;
          cnt_q <= rem - 1'b1;
        end
      end
    end
  end

  assign flag_a_o = act[0];
  assign flag_b_o = ilv_i ? act[1] : !act[0];

endmodule

module hyst_level_det_chk #(
  parameter int SW = 14,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [SW-1:0] smp_i,
  input logic          en_i,
  input logic          ilv_i,
  input logic [SW-1:0] thr_hi_i,
  input logic [SW-1:0] thr_lo_i,
  input logic [CW-1:0] dwell_i,
  input logic          flag_a_o,
  input logic          flag_b_o
);

  logic [1:0] armed;
  always_ff @(posedge clk) armed <= rst ? 2'b00 : {armed[0], 1'b1};
  wire live = armed[1];

  logic signed [SW:0] sx;
  logic [SW:0]        m_c;
  assign sx  = {smp_i[SW-1], smp_i};
  assign m_c = (sx < 0) ? ((-sx > (2**(SW-1) - 1)) ? (2**(SW-1) - 1) : -sx) : sx;

  wire to_a = !ilv_i || !en_i;

  // R2
  a_rise_needs_loud_chk: assert property (@(posedge clk) disable iff (rst || !live)
    $rose(flag_a_o) |-> $past(to_a && m_c >= {1'b0, thr_hi_i}));

  // R4
  a_fall_needs_quiet_chk: assert property (@(posedge clk) disable iff (rst || !live)
    ($fell(flag_a_o) && $past(ilv_i) == ilv_i) |-> $past(to_a && m_c < {1'b0, thr_lo_i}));

  // R3
  a_hold_above_lo_chk: assert property (@(posedge clk) disable iff (rst || !live)
    (flag_a_o && to_a && m_c >= {1'b0, thr_lo_i}) |=> flag_a_o);

  // R7
  b_sample_leaves_a_chk: assert property (@(posedge clk) disable iff (rst || !live)
    (ilv_i && en_i) |=> $stable(flag_a_o));

  // R7
  a_sample_leaves_b_chk: assert property (@(posedge clk) disable iff (rst || !live)
    (ilv_i && !en_i) ##1 ilv_i |-> $stable(flag_b_o));

  // R8
  single_mode_inverse_chk: assert property (@(posedge clk) disable iff (rst || !live)
    !ilv_i |-> (flag_b_o != flag_a_o));

endmodule

bind hyst_level_det hyst_level_det_chk #(.SW(SW), .CW(CW)) i_chk (
  .clk(clk), .rst(rst), .smp_i(smp_i), .en_i(en_i), .ilv_i(ilv_i),
  .thr_hi_i(thr_hi_i), .thr_lo_i(thr_lo_i), .dwell_i(dwell_i),
  .flag_a_o(flag_a_o), .flag_b_o(flag_b_o)
);

// File: tb/test_hyst_level_det.sv
module test_hyst_level_det;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] smp_i = '0;
  logic        en_i = 1'b0, ilv_i = 1'b0;
  logic [13:0] thr_hi_i = 14'd1000, thr_lo_i = 14'd500;
  logic [15:0] dwell_i = 16'd3;
  logic        flag_a_o, flag_b_o;

  int n_chk = 0, n_bad = 0;
  bit m_act[2], m_run[2];
  int m_cnt[2];

  always #2 clk = ~clk;

  hyst_level_det i_hyst_level_det (
    .clk(clk), .rst(rst), .smp_i(smp_i), .en_i(en_i), .ilv_i(ilv_i),
    .thr_hi_i(thr_hi_i), .thr_lo_i(thr_lo_i), .dwell_i(dwell_i),
    .flag_a_o(flag_a_o), .flag_b_o(flag_b_o)
  );

  function automatic int mag_of(logic [13:0] s);
    int v = $signed(s);
    if (v < 0) v = -v;
    return (v > 8191) ? 8191 : v;
  endfunction

  task automatic model_edge();
    int m = mag_of(smp_i);
    for (int d = 0; d < 2; d++) begin
      bit pick = (d == 0) ? (!ilv_i || !en_i) : (ilv_i && en_i);
      int rem;
      if (rst || (d == 1 && !ilv_i)) begin
        m_act[d] = 0; m_run[d] = 0; m_cnt[d] = 0;
      end else if (pick) begin
        rem = m_run[d] ? m_cnt[d] : int'(dwell_i);
        if (!m_act[d]) begin
          if (m >= int'(thr_hi_i)) m_act[d] = 1;
        end else if (m >= int'(thr_lo_i)) m_run[d] = 0;
        else if (rem == 0) begin m_act[d] = 0; m_run[d] = 0; end
        else begin m_run[d] = 1; m_cnt[d] = rem - 1; end
      end
    end
  endtask

  task automatic check(string tag);
    bit ea = m_act[0];
    bit eb = ilv_i ? m_act[1] : !m_act[0];
    n_chk++;
    if (flag_a_o !== ea || flag_b_o !== eb) begin
      n_bad++;
      $display("FAIL %s: flags a=%b b=%b expected a=%b b=%b", tag, flag_a_o, flag_b_o, ea, eb);
    end
  endtask

  task automatic step(int s, bit en, string tag);
    smp_i = 14'(s);
    en_i  = en;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) begin @(posedge clk); model_edge(); @(negedge clk); end
    check("R1");
    ilv_i = 1'b1; #0.1 check("R1");
    ilv_i = 1'b0;
    rst = 1'b0;

    step(999, 0, "R9");
    step(1000, 0, "R2");
    step(-1000, 0, "R3");
    step(400, 0, "R4");
    step(300, 0, "R4");
    step(600, 0, "R6");
    step(0, 0, "R6");
    step(0, 1, "R8");
    step(499, 0, "R4");
    step(0, 0, "R4");
    if (flag_a_o !== 1'b0) begin n_bad++; $display("FAIL R4: a=%b expected 0", flag_a_o); end
    n_chk++;

    thr_hi_i = 14'd8191;
    step(-8191, 0, "R2");
    step(-8192, 0, "R2");
    dwell_i = 16'd0;
    step(10, 0, "R5");

    ilv_i = 1'b1; thr_hi_i = 14'd1000; dwell_i = 16'd2;
    step(2000, 1, "R7");
    step(2000, 0, "R7");
    step(0, 1, "R7");
    step(0, 1, "R7");
    step(0, 0, "R7");
    step(0, 1, "R7");
    step(0, 0, "R7");
    step(0, 0, "R7");
    ilv_i = 1'b0;
    step(0, 1, "R8");

    for (int i = 0; i < 4000; i++) begin
      int s, pick;
      if (i % 250 == 0) begin
        thr_lo_i = 14'($urandom_range(0, 4000));
        thr_hi_i = 14'(int'(thr_lo_i) + $urandom_range(0, 4000));
        dwell_i  = 16'($urandom_range(0, 5));
      end
      if ($urandom_range(0, 19) == 0) ilv_i = ~ilv_i;
      pick = $urandom_range(0, 3);
      case (pick)
        0: s = int'(thr_hi_i) + $urandom_range(0, 3) - 1;
        1: s = int'(thr_lo_i) + $urandom_range(0, 3) - 1;
        2: s = $urandom_range(0, 200);
        default: s = $urandom_range(0, 16383) - 8192;
      endcase
      if ($urandom_range(0, 1) == 1) s = -s;
      step(s, 1'($urandom_range(0, 1)), ilv_i ? "R7" : "R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1729));
  end
endmodule